// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block moves a processor subsystem between a running state and three power-saving states: sleep, deep sleep and standby. The CPU raises a one-cycle sleep strobe. On that strobe the controller looks at two mode-select bits, one choosing standby and one choosing deep sleep, and picks the state to enter. It then drives clock enables for the CPU, for the on-chip peripherals and for the external clock-output pin. It also drives a two-bit status code to the package pins and a one-cycle clear strobe for the timer start register.

A non-maskable interrupt, a nonzero external interrupt level or a peripheral interrupt brings the subsystem back from any power-saving state. Sleep and deep sleep return to run on the next clock. Standby first runs an oscillator settling interval. Software preloads an 8-bit up-counter before standby and chooses its prescale rate. After a wake event the counter counts up from that value, and the clocks come back only when it overflows. An asynchronous reset returns to run at once, with every clock enabled.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: While reset is active and after it is released, the controller is in run. Run means cpu_clk_en_o=1, per_clk_en_o=1, clkout_en_o=1 and status_o=2'b00, with timer_start_clr_o=0.
- R2: A sleep strobe in run with standby_sel_i=1 (and no wake event) enters standby on that clock edge. In standby, all three clock enables are 0 and status_o=2'b01, meaning pin 1 low and pin 0 high.
- R3: A sleep strobe in run with standby_sel_i=0 and deep_sel_i=0 enters sleep. In sleep, cpu_clk_en_o=0, per_clk_en_o=1, clkout_en_o=1 and status_o=2'b10.
- R4: A sleep strobe in run with standby_sel_i=0 and deep_sel_i=1 enters deep sleep. In deep sleep, cpu_clk_en_o=0, per_clk_en_o=1, clkout_en_o=0 and status_o=2'b10.
- R5: A wake event is nmi_i=1, a nonzero irl_i or periph_irq_i=1. In sleep or deep sleep, a wake event returns the controller to run on the next clock edge.
- R6: timer_start_clr_o is high for exactly the one cycle after the edge that enters standby, and only if rtc_in_use_i=0 at that strobe. It stays low when rtc_in_use_i=1 and on entry to sleep or deep sleep.
- R7: A wake event in standby loads wdt_preload_i into the settling counter. The counter steps once every 2^(2*wdt_cks_i+1) clocks and overflows from 0xFF to 0x00. The clocks stay gated with status_o=2'b01 until the edge (256-preload)*2^(2*wdt_cks_i+1) clocks after the wake edge, when run resumes.
- R8: A wake event in the same cycle as the sleep strobe cancels entry, and the controller stays in run.
- R9: Asserting rst_n in any state forces the run outputs at once, with no clock edge and no settling wait.
- R10: A sleep strobe outside run, and a wake event in run, have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_strobe_i | input | 1 | One-cycle sleep request from the CPU |
| standby_sel_i | input | 1 | Mode select: standby when 1 |
| deep_sel_i | input | 1 | Mode select: deep sleep when 1 and standby not selected |
| nmi_i | input | 1 | Non-maskable interrupt |
| irl_i | input | 4 | Level-encoded external interrupt request, 0 = none |
| periph_irq_i | input | 1 | Peripheral interrupt request |
| rtc_in_use_i | input | 1 | Real-time clock in use; keeps the timer start register |
| wdt_preload_i | input | 8 | Settling counter preload |
| wdt_cks_i | input | 3 | Settling counter prescale select |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| clkout_en_o | output | 1 | External clock-output enable |
| status_o | output | 2 | Status pins {pin1, pin0} |
| timer_start_clr_o | output | 1 | Clear strobe for the timer start register |

## Verification
The assertions assume that the sleep strobe is a single-cycle pulse. They also assume that the preload and prescale inputs stay stable from the wake edge until the overflow, so that the step and hold properties describe one settling run. The bench drives every input on the falling edge. It holds the preload and prescale values fixed through each standby episode and keeps wake levels asserted for one cycle only. The settling checks use short counts: preload 0xF0 with the fastest rate, and preload 0xFC with the next rate. With these values the exact release edge can be sampled on both sides.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    LP_RUN    = 3'd0,
    LP_SLEEP  = 3'd1,
    LP_DEEP   = 3'd2,
    LP_STBY   = 3'd3,
    LP_SETTLE = 3'd4
  } lp_state_e;

  localparam logic [1:0] ST_RUN   = 2'b00;
  localparam logic [1:0] ST_SLEEP = 2'b10;
  localparam logic [1:0] ST_STBY  = 2'b01;
endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/lpm_prescaler.sv
module lpm_prescaler #(
  parameter int CKS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run_en,
  input  logic [CKS_W-1:0] cks,
  output logic             tick
);
  localparam int PRESC_W = 2 * ((1 << CKS_W) - 1) + 1;
  localparam int SH_W    = $clog2(PRESC_W) + 1;

  logic [PRESC_W-1:0] presc_q, presc_d, limit;

  always_comb begin
    limit = (PRESC_W'(1) << (SH_W'(cks) * SH_W'(2) + SH_W'(1))) - PRESC_W'(1);
    tick  = run_en && (presc_q == limit);
    if (restart)   presc_d = '0;
    else if (tick) presc_d = '0;
    else if (run_en) presc_d = presc_q + PRESC_W'(1);
    else           presc_d = presc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_d;
  end

  // R7: the divide is at least two, so a tick never repeats on the next clock
  p_tick_spaced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/lpm_settle_counter.sv
module lpm_settle_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] preload,
  input  logic             tick,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    overflow = tick && (cnt_q == CNT_MAX);
    if (load)      cnt_d = preload;
    else if (tick) cnt_d = cnt_q + CNT_W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  p_cnt_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(preload)));
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_strobe,
  input  logic      standby_sel,
  input  logic      deep_sel,
  input  logic      wake,
  input  logic      rtc_in_use,
  input  logic      settle_done,
  output lp_state_e state,
  output logic      settle_start,
  output logic      timer_clr
);
  lp_state_e state_d;
  logic      enter_req;
  logic      timer_clr_d;

  always_comb begin
    enter_req    = sleep_strobe && !wake;
    settle_start = (state == LP_STBY) && wake;
    state_d      = state;
    case (state)
      LP_RUN: begin
        if (enter_req) begin
          if (standby_sel)   state_d = LP_STBY;
          else if (deep_sel) state_d = LP_DEEP;
          else               state_d = LP_SLEEP;
        end
      end
      LP_SLEEP, LP_DEEP: if (wake) state_d = LP_RUN;
      LP_STBY:           if (wake) state_d = LP_SETTLE;
      LP_SETTLE:         if (settle_done) state_d = LP_RUN;
      default:           state_d = LP_RUN;
    endcase
    timer_clr_d = (state == LP_RUN) && enter_req && standby_sel && !rtc_in_use;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= LP_RUN;
      timer_clr <= 1'b0;
    end else begin
      state     <= state_d;
      timer_clr <= timer_clr_d;
    end
  end

  p_cancel_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LP_RUN && sleep_strobe && wake) |=> (state == LP_RUN));

  p_sleep_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == LP_SLEEP || state == LP_DEEP) && wake) |=> (state == LP_RUN));

  p_settle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LP_SETTLE && !settle_done) |=> (state == LP_SETTLE));

  p_clr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timer_clr |=> !timer_clr);

  p_clr_with_stby_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timer_clr |-> (state == LP_STBY));

  p_strobe_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == LP_SLEEP || state == LP_DEEP) && !wake) |=> $stable(state));
endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
  import lpm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CKS_W = 3,
  parameter int IRL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_strobe_i,
  input  logic             standby_sel_i,
  input  logic             deep_sel_i,
  input  logic             nmi_i,
  input  logic [IRL_W-1:0] irl_i,
  input  logic             periph_irq_i,
  input  logic             rtc_in_use_i,
  input  logic [CNT_W-1:0] wdt_preload_i,
  input  logic [CKS_W-1:0] wdt_cks_i,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             clkout_en_o,
  output logic [1:0]       status_o,
  output logic             timer_start_clr_o
);
  logic      rst_sync_n;
  logic      wake;
  logic      settle_start;
  logic      settle_done;
  logic      presc_tick;
  lp_state_e state;

  assign wake = nmi_i || (irl_i != '0) || periph_irq_i;

  lpm_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lpm_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .sleep_strobe (sleep_strobe_i),
    .standby_sel  (standby_sel_i),
    .deep_sel     (deep_sel_i),
    .wake         (wake),
    .rtc_in_use   (rtc_in_use_i),
    .settle_done  (settle_done),
    .state        (state),
    .settle_start (settle_start),
    .timer_clr    (timer_start_clr_o)
  );

  lpm_prescaler #(.CKS_W(CKS_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (settle_start),
    .run_en  (state == LP_SETTLE),
    .cks     (wdt_cks_i),
    .tick    (presc_tick)
  );

  lpm_settle_counter #(.CNT_W(CNT_W)) u_settle (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (settle_start),
    .preload  (wdt_preload_i),
    .tick     (presc_tick),
    .overflow (settle_done)
  );

  always_comb begin
    cpu_clk_en_o = 1'b1;
    per_clk_en_o = 1'b1;
    clkout_en_o  = 1'b1;
    status_o     = ST_RUN;
    case (state)
      LP_SLEEP: begin
        cpu_clk_en_o = 1'b0;
        status_o     = ST_SLEEP;
      end
      LP_DEEP: begin
        cpu_clk_en_o = 1'b0;
        clkout_en_o  = 1'b0;
        status_o     = ST_SLEEP;
      end
      LP_STBY, LP_SETTLE: begin
        cpu_clk_en_o = 1'b0;
        per_clk_en_o = 1'b0;
        clkout_en_o  = 1'b0;
        status_o     = ST_STBY;
      end
      default: ;
    endcase
  end

  p_stby_gated_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status_o == ST_STBY) |-> (!cpu_clk_en_o && !per_clk_en_o && !clkout_en_o));

  p_cpu_gated_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (status_o != ST_RUN) |-> !cpu_clk_en_o);

  p_reset_run_r9: assert property (@(posedge clk)
    !rst_n |-> (cpu_clk_en_o && per_clk_en_o && clkout_en_o && status_o == ST_RUN));
endmodule

// File: tb/lpm_seq_ctrl_bench.sv
`timescale 1ns/1ps
module lpm_seq_ctrl_bench;
  logic       clk;
  logic       rst_n;
  logic       sleep_strobe_i, standby_sel_i, deep_sel_i;
  logic       nmi_i, periph_irq_i, rtc_in_use_i;
  logic [3:0] irl_i;
  logic [7:0] wdt_preload_i;
  logic [2:0] wdt_cks_i;
  logic       cpu_clk_en_o, per_clk_en_o, clkout_en_o, timer_start_clr_o;
  logic [1:0] status_o;

  int n_run  = 0;
  int n_fail = 0;

  localparam logic [4:0] O_RUN   = 5'b111_00;
  localparam logic [4:0] O_SLEEP = 5'b011_10;
  localparam logic [4:0] O_DEEP  = 5'b010_10;
  localparam logic [4:0] O_STBY  = 5'b000_01;

  lpm_seq_ctrl u_lpm_seq_ctrl (
    .clk               (clk),
    .rst_n             (rst_n),
    .sleep_strobe_i    (sleep_strobe_i),
    .standby_sel_i     (standby_sel_i),
    .deep_sel_i        (deep_sel_i),
    .nmi_i             (nmi_i),
    .irl_i             (irl_i),
    .periph_irq_i      (periph_irq_i),
    .rtc_in_use_i      (rtc_in_use_i),
    .wdt_preload_i     (wdt_preload_i),
    .wdt_cks_i         (wdt_cks_i),
    .cpu_clk_en_o      (cpu_clk_en_o),
    .per_clk_en_o      (per_clk_en_o),
    .clkout_en_o       (clkout_en_o),
    .status_o          (status_o),
    .timer_start_clr_o (timer_start_clr_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [4:0] outs();
    return {cpu_clk_en_o, per_clk_en_o, clkout_en_o, status_o};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // drive a one-cycle strobe (optionally with a wake), sample after the edge
  task automatic strobe(input logic sby, input logic deep, input logic with_nmi);
    @(negedge clk);
    standby_sel_i  = sby;
    deep_sel_i     = deep;
    sleep_strobe_i = 1'b1;
    nmi_i          = with_nmi;
    @(posedge clk); #1;
    @(negedge clk);
    sleep_strobe_i = 1'b0;
    nmi_i          = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #1;
    check("R1 outputs in reset", {3'b0, outs()}, {3'b0, O_RUN});
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 outputs after release", {3'b0, outs()}, {3'b0, O_RUN});
    check("R1 clear strobe idle", {7'b0, timer_start_clr_o}, 8'd0);
  endtask

  task automatic t_sleep();
    @(negedge clk);
    standby_sel_i = 1'b0; deep_sel_i = 1'b0; sleep_strobe_i = 1'b1;
    @(posedge clk); #1;
    check("R3 sleep outputs", {3'b0, outs()}, {3'b0, O_SLEEP});
    check("R6 no clear on sleep", {7'b0, timer_start_clr_o}, 8'd0);
    @(negedge clk);
    sleep_strobe_i = 1'b0;
    strobe(1'b1, 1'b0, 1'b0);
    check("R10 strobe in sleep ignored", {3'b0, outs()}, {3'b0, O_SLEEP});
    @(negedge clk);
    irl_i = 4'd3;
    @(posedge clk); #1;
    check("R5 irl wake from sleep", {3'b0, outs()}, {3'b0, O_RUN});
    @(negedge clk);
    irl_i = 4'd0;
  endtask

  task automatic t_deep();
    strobe(1'b0, 1'b1, 1'b0);
    check("R4 deep sleep outputs", {3'b0, outs()}, {3'b0, O_DEEP});
    @(negedge clk);
    periph_irq_i = 1'b1;
    @(posedge clk); #1;
    check("R5 peripheral wake from deep", {3'b0, outs()}, {3'b0, O_RUN});
    @(negedge clk);
    periph_irq_i = 1'b0;
  endtask

  task automatic t_cancel_and_run_wake();
    strobe(1'b1, 1'b0, 1'b1);
    check("R8 wake with strobe cancels", {3'b0, outs()}, {3'b0, O_RUN});
    check("R8 no clear on cancel", {7'b0, timer_start_clr_o}, 8'd0);
    @(negedge clk);
    nmi_i = 1'b1;
    @(posedge clk); #1;
    check("R10 wake in run no effect", {3'b0, outs()}, {3'b0, O_RUN});
    @(negedge clk);
    nmi_i = 1'b0;
  endtask

  task automatic t_standby(input logic [7:0] pre, input logic [2:0] cks, input logic rtc);
    int n;
    n = (256 - int'(pre)) * (1 << (2 * int'(cks) + 1));
    @(negedge clk);
    wdt_preload_i = pre; wdt_cks_i = cks; rtc_in_use_i = rtc;
    standby_sel_i = 1'b1; deep_sel_i = 1'b0; sleep_strobe_i = 1'b1;
    @(posedge clk); #1;
    check("R2 standby outputs", {3'b0, outs()}, {3'b0, O_STBY});
    check("R6 clear on standby entry", {7'b0, timer_start_clr_o}, {7'b0, !rtc});
    @(negedge clk);
    sleep_strobe_i = 1'b0;
    @(posedge clk); #1;
    check("R6 clear lasts one cycle", {7'b0, timer_start_clr_o}, 8'd0);
    repeat (5) @(posedge clk);
    #1;
    check("R2 standby held without wake", {3'b0, outs()}, {3'b0, O_STBY});
    @(negedge clk);
    nmi_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    nmi_i = 1'b0;
    repeat (n - 1) @(posedge clk);
    #1;
    check("R7 still gated before overflow", {3'b0, outs()}, {3'b0, O_STBY});
    @(posedge clk); #1;
    check("R7 run after overflow", {3'b0, outs()}, {3'b0, O_RUN});
    rtc_in_use_i = 1'b0;
  endtask

  task automatic t_reset_in_standby();
    strobe(1'b1, 1'b0, 1'b0);
    check("R2 standby before reset", {3'b0, outs()}, {3'b0, O_STBY});
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check("R9 async reset forces run", {3'b0, outs()}, {3'b0, O_RUN});
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R9 run after reset release", {3'b0, outs()}, {3'b0, O_RUN});
  endtask

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    sleep_strobe_i = 1'b0; standby_sel_i = 1'b0; deep_sel_i = 1'b0;
    nmi_i = 1'b0; periph_irq_i = 1'b0; rtc_in_use_i = 1'b0;
    irl_i = 4'd0; wdt_preload_i = 8'hF0; wdt_cks_i = 3'd0;
    t_reset();
    t_sleep();
    t_deep();
    t_cancel_and_run_wake();
    t_standby(8'hF0, 3'd0, 1'b0);
    t_standby(8'hFC, 3'd1, 1'b1);
    t_standby(8'hFF, 3'd0, 1'b0);
    t_reset_in_standby();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule